// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small first-in first-out store of instruction bytes ahead of an execution unit that takes them one at a time. It decides on its own when to ask a 16-bit fetch port for more code. Each fetch brings in two bytes when the fetch address is even and one byte when it is odd. The fetch address then advances by the same amount.

Operand traffic from the execution side takes priority over new prefetches. A prefetch that has already been issued still runs to completion first. When the program takes a jump, a flush input empties the store, drops any fetch still in flight, and restarts fetching at a new 16-bit target. The fetch port is a plain request/acknowledge pair. The request stays up, with a stable address, until it is acknowledged in the same cycle.

Top module: `prefetch_queue`

## Requirements
- R1: The queue holds at most DEPTH bytes (default 6). `count` reports the number held, from 0 to DEPTH, and `empty` is high exactly when `count` is 0.
- R2: A new fetch request rises only when at least two slots are free, `operand_pending` is low and `flush` is low.
- R3: A fetch acknowledged at an even address appends two bytes: first `fetch_data[7:0]`, then `fetch_data[15:8]`. A fetch acknowledged at an odd address appends the single byte `fetch_data[15:8]`.
- R4: Once a request is raised, it stays high with an unchanged `fetch_addr` until a cycle with `fetch_ack` high, whatever `operand_pending` does. Only a flush withdraws it.
- R5: `out_byte` shows the oldest byte while `empty` is low, and `pop` removes it. A `pop` while empty has no effect. A pop and a fetch in the same cycle keep both the byte order and the count exact.
- R6: When `flush` is high, the next cycle has an empty queue and `fetch_addr` equal to `flush_target`. Any pop, and any acknowledge of an in-flight fetch, in the flush cycle are discarded. `fetch_req` is low during the flush cycle.
- R7: After an acknowledged fetch, `fetch_addr` advances by 2 from an even address and by 1 from an odd address.
- R8: While reset is active, `count` is 0, `empty` is 1, `fetch_addr` is 0 and `fetch_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_req | output | 1 | Request for a code fetch |
| fetch_addr | output | AW | Byte address of the requested fetch |
| fetch_ack | input | 1 | Fetch completes; data valid this cycle |
| fetch_data | input | 16 | Fetched word; byte lanes as in R3 |
| operand_pending | input | 1 | Execution side wants the bus for an operand |
| pop | input | 1 | Consume the byte at the output end |
| out_byte | output | 8 | Oldest byte in the queue |
| empty | output | 1 | Queue holds no byte |
| count | output | $clog2(DEPTH+1) | Number of bytes held |
| flush | input | 1 | Control transfer: empty and redirect |
| flush_target | input | AW | New fetch address on flush |

## Verification
The bench builds the block with its defaults: DEPTH of 6 and a 16-bit address. With a depth of six, both the "room for two" threshold and the full condition come up often under random popping. The full 16-bit target range lets flushes land on odd and even addresses and wrap the pointer. Four phases shift the odds of pop, operand traffic, acknowledge and flush, so that the queue runs full, runs dry, and has requests held against operand traffic.

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
  parameter int DEPTH = 6,
  parameter int AW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_ack,
  input  logic [15:0]   fetch_data,
  input  logic          operand_pending,
  input  logic          pop,
  output logic [7:0]    out_byte,
  output logic          empty,
  output logic [$clog2(DEPTH+1)-1:0] count,
  input  logic          flush,
  input  logic [AW-1:0] flush_target
);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]    slot [DEPTH];
  logic          inflight;
  logic [CW-1:0] base;
  logic [1:0]    n_in;
  logic          take, do_pop, start_ok;
  logic [7:0]    b0, b1;

  assign start_ok  = ~inflight & (int'(count) <= DEPTH - 2) & ~operand_pending & ~flush;
  assign fetch_req = rst_n & ((inflight & ~flush) | start_ok);
  assign take      = fetch_req & fetch_ack & ~flush;
  assign do_pop    = pop & (count != '0) & ~flush;
  assign n_in      = take ? (fetch_addr[0] ? 2'd1 : 2'd2) : 2'd0;
  assign b0        = fetch_addr[0] ? fetch_data[15:8] : fetch_data[7:0];
  assign b1        = fetch_data[15:8];
  assign base      = count - CW'(do_pop);
  assign empty     = (count == '0);
  assign out_byte  = slot[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count      <= '0;
      fetch_addr <= '0;
      inflight   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= 8'h00;
    end else if (flush) begin
      count      <= '0;
      fetch_addr <= flush_target;
      inflight   <= 1'b0;
    end else begin
      count    <= base + CW'(n_in);
      inflight <= fetch_req & ~fetch_ack;
      if (take) fetch_addr <= fetch_addr + AW'(n_in);
      for (int i = 0; i < DEPTH; i++) begin
        if (do_pop && i + 1 < DEPTH) slot[i] <= slot[i+1];
        if (take && i == int'(base)) slot[i] <= b0;
        if (take && n_in == 2'd2 && i == int'(base) + 1) slot[i] <= b1;
      end
    end
  end

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH); // R1

  AST_REQ_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_req) |-> (int'(count) <= DEPTH - 2) && !operand_pending && !flush); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack && !flush) |=> flush || (fetch_req && $stable(fetch_addr))); // R4

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0) && (fetch_addr == $past(flush_target))); // R6

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack && !flush) |=>
      fetch_addr == $past(fetch_addr) + ($past(fetch_addr[0]) ? AW'(1) : AW'(2))); // R7
endmodule

// File: tb/prefetch_queue_test.sv
module prefetch_queue_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 6;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_req, fetch_ack = 1'b0;
  logic [AW-1:0] fetch_addr, flush_target = '0;
  logic [15:0] fetch_data = '0;
  logic operand_pending = 1'b0, pop = 1'b0, flush = 1'b0;
  logic [7:0] out_byte;
  logic empty;
  logic [2:0] count;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  logic [7:0] mq [$];
  logic [AW-1:0] m_addr = '0;
  bit m_infl = 0;
  bit prev_flush = 0;

  prefetch_queue #(.DEPTH(DEPTH), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .fetch_addr(fetch_addr),
    .fetch_ack(fetch_ack), .fetch_data(fetch_data), .operand_pending(operand_pending),
    .pop(pop), .out_byte(out_byte), .empty(empty), .count(count),
    .flush(flush), .flush_target(flush_target));

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles++;

  function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
    return 8'((a * 7 + 3) ^ (a >> 8));
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic step(int p_pop, int p_op, int p_ack, int p_flush);
    int free;
    bit exp_req;
    @(negedge clk);
    pop = ($urandom_range(99) < p_pop);
    operand_pending = ($urandom_range(99) < p_op);
    fetch_ack = ($urandom_range(99) < p_ack);
    flush = ($urandom_range(999) < p_flush);
    flush_target = AW'($urandom_range(65535));
    fetch_data = m_addr[0] ? {mem_byte(m_addr), 8'h5A}
                           : {mem_byte(m_addr + 1'b1), mem_byte(m_addr)};
    #1;
    free = DEPTH - mq.size();
    exp_req = m_infl ? !flush : (free >= 2 && !operand_pending && !flush);
    check(m_infl ? "R4 fetch_req held" : "R2 fetch_req", int'(fetch_req), int'(exp_req));
    check(prev_flush ? "R6 fetch_addr after flush" : "R7 fetch_addr", int'(fetch_addr), int'(m_addr));
    check(prev_flush ? "R6 count after flush" : "R1 count", int'(count), mq.size());
    check("R1 empty", int'(empty), int'(mq.size() == 0));
    if (mq.size() > 0) check("R3 R5 out_byte", int'(out_byte), int'(mq[0]));
    prev_flush = flush;
    if (flush) begin
      mq.delete();
      m_addr = flush_target;
      m_infl = 0;
    end else begin
      if (pop && mq.size() > 0) void'(mq.pop_front());
      if (exp_req && fetch_ack) begin
        mq.push_back(mem_byte(m_addr));
        if (!m_addr[0]) mq.push_back(mem_byte(m_addr + 1'b1));
        m_addr = m_addr + (m_addr[0] ? 1 : 2);
      end
      m_infl = exp_req && !fetch_ack;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    #1;
    check("R8 reset count", int'(count), 0);
    check("R8 reset empty", int'(empty), 1);
    check("R8 reset fetch_addr", int'(fetch_addr), 0);
    check("R8 reset fetch_req", int'(fetch_req), 0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 1500; i++) step(10, 0, 80, 2);
    for (int i = 0; i < 1500; i++) step(90, 10, 40, 2);
    for (int i = 0; i < 1500; i++) step(50, 60, 30, 5);
    for (int i = 0; i < 2000; i++) step(40, 20, 50, 60);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule